// File: doc/BRIEF.md
# J1850 Byte-Level Transmit Sequencer

This block runs the transmit side of a J1850 data-link controller. Software hands it a message one byte at a time through a data write port. The first write, made while the block is idle, arms a transmit request. The block waits for the bus to go idle, then asks the symbol layer for a start-of-frame symbol. After that it shifts each byte out most significant bit first, one bit symbol per request. Each time a byte moves from the holding register into the shifter, a transmit-empty flag tells software it may write the next byte.

Software marks the end of the message with a single end-of-data command. Once the last byte has gone out, the block sends the ones' complement of an 8-bit CRC taken over every message byte, followed by an end-of-data symbol. The symbol layer handles pulse timing. It acknowledges each symbol and echoes the bus level it saw.

If a recessive bit comes back dominant, arbitration is lost. The frame stops at once, the pending end-of-data command is dropped, and a sticky flag is raised. If the shifter empties with neither a new byte nor an end-of-data command supplied, the frame is abandoned with an underrun flag.

Top module: `j1850_tx_seq`

## Requirements
- R1: A data write while idle starts a request. No symbol is requested until `bus_idle_i` is high. The frame is then a start-of-frame symbol followed by the byte's bits, MSB first. Symbol codes on `sym_code_o`: 00 start-of-frame, 01 end-of-data, 10 bit zero, 11 bit one. A request and its code hold steady until `sym_ack_i`.
- R2: While the request waits for the bus, each further data write replaces the pending first byte and does not start a second frame.
- R3: `tdre_o` rises when a byte moves into the shifter and is not the marked last byte. The next data write clears it.
- R4: After the last byte, the block sends the ones' complement of the CRC as eight bit symbols, MSB first, then one end-of-data symbol, then returns to idle. The CRC uses polynomial x^8+x^4+x^3+x^2+1, is preset to 0xFF, and is updated MSB first over all message bytes. For ASCII "123456789" the transmitted CRC byte is 0x4B.
- R5: The end-of-data command clears `tdre_o`, and `tdre_o` stays low for the rest of that message.
- R6: The end-of-data command is accepted either in the cycle after the last data write or after `tdre_o` has shown for the last byte. Both give the same frame.
- R7: Arbitration is lost when a bit-one symbol is acknowledged with `sym_echo_i` low. The next cycle shows `loa_o` high and no symbol request. The end-of-data command is cancelled, so a following frame without a new command ends in underrun.
- R8: If a byte's last bit completes while no new byte is held and no end-of-data command is pending, the frame stops and `urun_o` is set.
- R9: Message length has no limit. A 20-byte message is sent in full.
- R10: An end-of-data command given while idle has no effect. Data writes made after the end-of-data command, until the frame ends, are ignored.
- R11: Reset clears all status flags and leaves no request. `loa_o` and `urun_o` stay set until cleared through `stat_clr_i` bit 0 and bit 1 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_i | input | 8 | Byte to write |
| eod_set_i | input | 1 | End-of-data command pulse |
| stat_clr_i | input | 2 | Status clear: bit 0 loss flag, bit 1 underrun flag |
| bus_idle_i | input | 1 | Bus is free for a new frame |
| sym_ack_i | input | 1 | Symbol layer finished the requested symbol |
| sym_echo_i | input | 1 | Bus level seen for the bit (1 = recessive) |
| sym_req_o | output | 1 | Symbol request |
| sym_code_o | output | 2 | Requested symbol code |
| tdre_o | output | 1 | Data register empty, next byte wanted |
| loa_o | output | 1 | Arbitration lost (sticky) |
| urun_o | output | 1 | Transmit underrun (sticky) |

## Verification
Cancellation of the end-of-data command on arbitration loss is the hardest case to bring about from the ports. The command's state is internal, and it only shows once a later frame ends. The stimulus arms a message, issues the end-of-data command at once, and has the symbol model echo a dominant level on an early bit-one. It then sends a single byte with no command and expects an underrun instead of a CRC. The waiting-phase byte replacement is reached by holding the bus busy across two writes.

// File: rtl/j1850_tx_pkg.sv
package j1850_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 8;

  typedef enum logic [1:0] {
    SYM_SOF  = 2'b00,
    SYM_EOD  = 2'b01,
    SYM_BIT0 = 2'b10,
    SYM_BIT1 = 2'b11
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SOF,
    ST_BITS,
    ST_EOD
  } tx_st_e;

  // one byte folded into the CRC, MSB first
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0]  c_in,
    input logic [BYTE_W-1:0] d,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/j1850_crc_acc.sv
module j1850_crc_acc
  import j1850_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h1D,
  parameter logic [CRC_W-1:0] INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= INIT;
    else if (init_i) crc_q <= crc_step(INIT, byte_i, POLY);
    else if (upd_i)  crc_q <= crc_step(crc_q, byte_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/j1850_tx_hold.sv
module j1850_tx_hold
  import j1850_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              eod_set_i,
  input  logic              idle_i,
  input  logic              accept_wr_i,
  input  logic              take_i,
  input  logic              abort_i,
  output logic              start_o,
  output logic              full_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              eod_o,
  output logic              tdre_o
);
  logic              full_q, eod_q, tdre_q;
  logic [BYTE_W-1:0] data_q;
  logic              accept;

  assign accept  = wr_i & (idle_i | accept_wr_i);
  assign start_o = wr_i & idle_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      eod_q  <= 1'b0;
      tdre_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) data_q <= wdata_i;

      if (abort_i)     full_q <= 1'b0;
      else if (accept) full_q <= 1'b1;
      else if (take_i) full_q <= 1'b0;

      if (abort_i)                  eod_q <= 1'b0;
      else if (eod_set_i & ~idle_i) eod_q <= 1'b1;

      if (abort_i | accept | eod_set_i) tdre_q <= 1'b0;
      else if (take_i & ~eod_q)         tdre_q <= 1'b1;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign eod_o  = eod_q;
  assign tdre_o = tdre_q;
endmodule

// File: rtl/j1850_tx_fsm.sv
module j1850_tx_fsm
  import j1850_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              bus_idle_i,
  input  logic              hold_full_i,
  input  logic [BYTE_W-1:0] hold_data_i,
  input  logic              eod_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic              sym_ack_i,
  input  logic              echo_i,
  output logic              sym_req_o,
  output logic [1:0]        sym_code_o,
  output logic              idle_o,
  output logic              accept_wr_o,
  output logic              take_o,
  output logic              crc_init_o,
  output logic              crc_upd_o,
  output logic              loss_o,
  output logic              urun_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  tx_st_e            st;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bcnt;
  logic              in_crc;
  logic              last_bit, sent_rec, ack_bits, byte_end, to_crc, frame_go;

  assign last_bit = (bcnt == CNT_W'(BYTE_W - 1));
  assign sent_rec = shreg[BYTE_W-1];
  assign ack_bits = (st == ST_BITS) & sym_ack_i;
  assign loss_o   = ack_bits & sent_rec & ~echo_i;
  assign byte_end = ack_bits & ~loss_o & last_bit;
  assign frame_go = (st == ST_WAIT) & bus_idle_i;

  assign crc_upd_o  = byte_end & ~in_crc & hold_full_i;
  assign crc_init_o = frame_go;
  assign take_o     = frame_go | crc_upd_o;
  assign to_crc     = byte_end & ~in_crc & ~hold_full_i & eod_i;
  assign urun_o     = byte_end & ~in_crc & ~hold_full_i & ~eod_i;
  assign done_o     = (st == ST_EOD) & sym_ack_i;

  assign idle_o      = (st == ST_IDLE);
  assign sym_req_o   = (st == ST_SOF) | (st == ST_BITS) | (st == ST_EOD);
  assign accept_wr_o = ((st == ST_WAIT) | (st == ST_SOF) | (st == ST_BITS))
                       & ~in_crc & ~eod_i;

  always_comb begin
    case (st)
      ST_BITS: sym_code_o = sent_rec ? SYM_BIT1 : SYM_BIT0;
      ST_EOD:  sym_code_o = SYM_EOD;
      default: sym_code_o = SYM_SOF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      shreg  <= '0;
      bcnt   <= '0;
      in_crc <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          in_crc <= 1'b0;
          if (start_i) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bus_idle_i) begin
            st    <= ST_SOF;
            shreg <= hold_data_i;
            bcnt  <= '0;
          end
        end
        ST_SOF: begin
          if (sym_ack_i) st <= ST_BITS;
        end
        ST_BITS: begin
          if (sym_ack_i) begin
            if (loss_o) begin
              st <= ST_IDLE;
            end else if (last_bit) begin
              bcnt <= '0;
              if (in_crc) begin
                st <= ST_EOD;
              end else if (hold_full_i) begin
                shreg <= hold_data_i;
              end else if (to_crc) begin
                shreg  <= ~crc_i;
                in_crc <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              bcnt  <= bcnt + CNT_W'(1);
            end
          end
        end
        ST_EOD: begin
          if (sym_ack_i) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/j1850_tx_seq.sv
module j1850_tx_seq
  import j1850_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [CRC_W-1:0] CRC_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dat_wr_i,
  input  logic [BYTE_W-1:0] dat_i,
  input  logic              eod_set_i,
  input  logic [1:0]        stat_clr_i,
  input  logic              bus_idle_i,
  input  logic              sym_ack_i,
  input  logic              sym_echo_i,
  output logic              sym_req_o,
  output logic [1:0]        sym_code_o,
  output logic              tdre_o,
  output logic              loa_o,
  output logic              urun_o
);
  // internal events, named for the checker
  logic              idle_w, accept_w, take_w, start_w, abort_w;
  logic              crc_init_w, crc_upd_w;
  logic              loss_ev, urun_ev, done_ev;
  logic              hold_full_w, eod_w;
  logic [BYTE_W-1:0] hold_data_w;
  logic [CRC_W-1:0]  crc_w;
  logic              loa_q, urun_q;

  assign abort_w = loss_ev | urun_ev | done_ev;

  j1850_tx_hold u_hold (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (dat_wr_i),
    .wdata_i     (dat_i),
    .eod_set_i   (eod_set_i),
    .idle_i      (idle_w),
    .accept_wr_i (accept_w),
    .take_i      (take_w),
    .abort_i     (abort_w),
    .start_o     (start_w),
    .full_o      (hold_full_w),
    .data_o      (hold_data_w),
    .eod_o       (eod_w),
    .tdre_o      (tdre_o)
  );

  j1850_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk    (clk),
    .rst    (rst),
    .init_i (crc_init_w),
    .upd_i  (crc_upd_w),
    .byte_i (hold_data_w),
    .crc_o  (crc_w)
  );

  j1850_tx_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_w),
    .bus_idle_i  (bus_idle_i),
    .hold_full_i (hold_full_w),
    .hold_data_i (hold_data_w),
    .eod_i       (eod_w),
    .crc_i       (crc_w),
    .sym_ack_i   (sym_ack_i),
    .echo_i      (sym_echo_i),
    .sym_req_o   (sym_req_o),
    .sym_code_o  (sym_code_o),
    .idle_o      (idle_w),
    .accept_wr_o (accept_w),
    .take_o      (take_w),
    .crc_init_o  (crc_init_w),
    .crc_upd_o   (crc_upd_w),
    .loss_o      (loss_ev),
    .urun_o      (urun_ev),
    .done_o      (done_ev)
  );

  // sticky status: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      loa_q  <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      if (loss_ev)            loa_q <= 1'b1;
      else if (stat_clr_i[0]) loa_q <= 1'b0;
      if (urun_ev)            urun_q <= 1'b1;
      else if (stat_clr_i[1]) urun_q <= 1'b0;
    end
  end

  assign loa_o  = loa_q;
  assign urun_o = urun_q;
endmodule

// File: rtl/j1850_tx_seq_chk.sv
module j1850_tx_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       dat_wr_i,
  input logic       eod_set_i,
  input logic [1:0] stat_clr_i,
  input logic       sym_ack_i,
  input logic       sym_req_o,
  input logic [1:0] sym_code_o,
  input logic       tdre_o,
  input logic       loa_o,
  input logic       urun_o,
  input logic       idle_w,
  input logic       loss_ev,
  input logic       urun_ev,
  input logic       done_ev
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    idle_w |-> !sym_req_o);

  a_r1_write_starts: assert property (@(posedge clk) disable iff (rst)
    (idle_w && dat_wr_i) |=> !idle_w);

  a_r1_symbol_held: assert property (@(posedge clk) disable iff (rst)
    (sym_req_o && !sym_ack_i) |=> (sym_req_o && $stable(sym_code_o)));

  a_r5_eod_clears_tdre: assert property (@(posedge clk) disable iff (rst)
    eod_set_i |=> !tdre_o);

  a_r7_loss_halts: assert property (@(posedge clk) disable iff (rst)
    loss_ev |=> (loa_o && !sym_req_o));

  a_r8_underrun_halts: assert property (@(posedge clk) disable iff (rst)
    urun_ev |=> (urun_o && !sym_req_o));

  a_r11_loa_sticky: assert property (@(posedge clk) disable iff (rst)
    (loa_o && !stat_clr_i[0]) |=> loa_o);

  a_r11_urun_sticky: assert property (@(posedge clk) disable iff (rst)
    (urun_o && !stat_clr_i[1]) |=> urun_o);

  a_r7_end_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loss_ev, urun_ev, done_ev}));
endmodule

bind j1850_tx_seq j1850_tx_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dat_wr_i   (dat_wr_i),
  .eod_set_i  (eod_set_i),
  .stat_clr_i (stat_clr_i),
  .sym_ack_i  (sym_ack_i),
  .sym_req_o  (sym_req_o),
  .sym_code_o (sym_code_o),
  .tdre_o     (tdre_o),
  .loa_o      (loa_o),
  .urun_o     (urun_o),
  .idle_w     (idle_w),
  .loss_ev    (loss_ev),
  .urun_ev    (urun_ev),
  .done_ev    (done_ev)
);

// File: tb/sim_j1850_tx_seq.sv
`timescale 1ns/1ps
module sim_j1850_tx_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dat_wr_i = 1'b0;
  logic [7:0] dat_i = 8'h00;
  logic       eod_set_i = 1'b0;
  logic [1:0] stat_clr_i = 2'b00;
  logic       bus_idle_i = 1'b1;
  logic       sym_ack_i = 1'b0;
  logic       sym_echo_i = 1'b1;
  logic       sym_req_o;
  logic [1:0] sym_code_o;
  logic       tdre_o, loa_o, urun_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] msg [0:31];
  logic [1:0] expq [0:1023];
  int         e_n;
  logic [1:0] log_q [0:1023];
  int         log_n = 0;
  int         loss_at = -1;
  int         dly = 0;
  longint     cyc = 0;

  always #5 clk = ~clk;

  j1850_tx_seq u0 (
    .clk(clk), .rst(rst), .dat_wr_i(dat_wr_i), .dat_i(dat_i),
    .eod_set_i(eod_set_i), .stat_clr_i(stat_clr_i), .bus_idle_i(bus_idle_i),
    .sym_ack_i(sym_ack_i), .sym_echo_i(sym_echo_i), .sym_req_o(sym_req_o),
    .sym_code_o(sym_code_o), .tdre_o(tdre_o), .loa_o(loa_o), .urun_o(urun_o)
  );

  // symbol layer model: random latency, records every acknowledged symbol
  always @(negedge clk) begin
    if (rst) begin
      sym_ack_i = 1'b0;
      dly = 0;
    end else if (sym_ack_i) begin
      sym_ack_i = 1'b0;
    end else if (sym_req_o) begin
      if (dly > 0) dly = dly - 1;
      else begin
        sym_ack_i  = 1'b1;
        sym_echo_i = (sym_code_o == 2'b11);
        if (log_n == loss_at && sym_code_o == 2'b11) sym_echo_i = 1'b0;
        log_q[log_n % 1024] = sym_code_o;
        log_n = log_n + 1;
        dly = $urandom % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        logic top;
        top = c[7] ^ msg[i][b];
        c = {c[6:0], 1'b0} ^ (top ? 8'b0001_1101 : 8'h00);
      end
    return c;
  endfunction

  task automatic build_exp(input int n);
    logic [7:0] tx;
    e_n = 0;
    expq[e_n++] = 2'b00;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) expq[e_n++] = msg[i][b] ? 2'b11 : 2'b10;
    tx = ~crc_ref(n);
    for (int b = 7; b >= 0; b--) expq[e_n++] = tx[b] ? 2'b11 : 2'b10;
    expq[e_n++] = 2'b01;
  endtask

  task automatic wr(input logic [7:0] b);
    dat_wr_i = 1'b1; dat_i = b;
    @(negedge clk);
    dat_wr_i = 1'b0;
  endtask

  task automatic eod_pulse();
    eod_set_i = 1'b1;
    @(negedge clk);
    eod_set_i = 1'b0;
  endtask

  task automatic wait_tdre(output bit seen);
    int t = 0;
    while (!tdre_o && t < 3000) begin @(negedge clk); t++; end
    seen = tdre_o;
  endtask

  // waits for the end of a frame; flags tdre if it shows; optional ignored write
  task automatic wait_end(input int base, input bit inj, output bit tdre_seen);
    int t = 0;
    tdre_seen = 0;
    while (t < 4000) begin
      if (tdre_o) tdre_seen = 1;
      if (loa_o || urun_o) break;
      if (log_n > base && log_q[(log_n - 1) % 1024] == 2'b01) break;
      if (inj && t == 5) wr(8'h5A);
      else @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_frame(input int base, input int n, input string req);
    int got = log_n - base;
    bit ok;
    build_exp(n);
    ok = (got == e_n);
    for (int k = 0; k < e_n && ok; k++)
      if (log_q[(base + k) % 1024] !== expq[k]) ok = 0;
    chk(ok, req, got, e_n);
  endtask

  // full message: mode 0 = eod right after last write, 1 = after tdre
  task automatic run_msg(input int n, input int mode, input bit inj, input string req);
    int base = log_n;
    bit seen, r3_ok = 1, r5_seen;
    wr(msg[0]);
    for (int i = 1; i < n; i++) begin
      wait_tdre(seen);
      if (!seen) r3_ok = 0;
      wr(msg[i]);
      if (tdre_o) r3_ok = 0;
    end
    if (mode == 1) begin
      wait_tdre(seen);
      if (!seen) r3_ok = 0;
    end
    eod_pulse();
    wait_end(base, inj, r5_seen);
    chk(r3_ok, "R3 tdre handshake", r3_ok, 1);
    chk(!r5_seen, "R5 tdre quiet after eod", r5_seen, 0);
    cmp_frame(base, n, req);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    bit dummy;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!sym_req_o && !tdre_o && !loa_o && !urun_o, "R11 reset state",
        {sym_req_o, tdre_o, loa_o, urun_o}, 0);

    // R4 known vector "123456789"
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    chk(~crc_ref(9) == 8'h4B, "R4 crc check value", ~crc_ref(9), 8'h4B);
    run_msg(9, 0, 0, "R4 frame 123456789");

    // R2 replacement while waiting for the bus; R1 no request while busy
    bus_idle_i = 1'b0;
    base = log_n;
    wr(8'hA5);
    wr(8'h3C);
    eod_pulse();
    repeat (10) @(negedge clk);
    chk(!sym_req_o && log_n == base, "R1 waits for idle bus", sym_req_o, 0);
    bus_idle_i = 1'b1;
    msg[0] = 8'h3C;
    wait_end(base, 0, dummy);
    cmp_frame(base, 1, "R2 replaced first byte");

    // R10 eod while idle ignored; R8 underrun on missing data
    eod_pulse();
    repeat (3) @(negedge clk);
    base = log_n;
    wr(8'hC3);
    wait_end(base, 0, dummy);
    chk(urun_o && !sym_req_o, "R8 underrun flagged", urun_o, 1);
    chk(log_n - base == 9, "R10 idle eod ignored, R8 stop after byte", log_n - base, 9);
    repeat (20) @(negedge clk);
    chk(urun_o, "R11 underrun sticky", urun_o, 1);
    stat_clr_i = 2'b10; @(negedge clk); stat_clr_i = 2'b00;
    chk(!urun_o, "R11 underrun cleared", urun_o, 0);

    // R7 arbitration loss on 4th bit of 0xFF, eod already given
    base = log_n;
    loss_at = base + 4;
    wr(8'hFF);
    eod_pulse();
    wait_end(base, 0, dummy);
    loss_at = -1;
    chk(loa_o && !sym_req_o, "R7 loss flagged and bus released", loa_o, 1);
    chk(log_n - base == 5, "R7 no symbols after loss", log_n - base, 5);
    chk(!urun_o, "R7 no underrun on loss", urun_o, 0);
    stat_clr_i = 2'b01; @(negedge clk); stat_clr_i = 2'b00;
    chk(!loa_o, "R11 loss cleared", loa_o, 0);
    base = log_n;
    wr(8'h81);
    wait_end(base, 0, dummy);
    chk(urun_o && log_n - base == 9, "R7 eod cancelled by loss", log_n - base, 9);
    stat_clr_i = 2'b10; @(negedge clk); stat_clr_i = 2'b00;

    // R9 long message, R6 late eod, R10 ignored write after eod
    for (int i = 0; i < 20; i++) msg[i] = 8'($urandom);
    run_msg(20, 1, 1, "R9 20-byte frame");

    // random messages, R6 both eod timings
    for (int k = 0; k < 30; k++) begin
      int n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      if (k % 5 == 0) begin msg[0] = 8'h00; end
      run_msg(n, $urandom % 2, ($urandom % 3) == 0, "R6 R4 random frame");
      repeat ($urandom % 4) @(negedge clk);
    end
    chk(!loa_o && !urun_o, "R11 no spurious status", {loa_o, urun_o}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule